// File: doc/BRIEF.md
# Comma Symbol Aligner with Jog

This block sits between a deserializer and an 8b/10b decoder. The deserializer delivers raw 10-bit words whose boundaries have no fixed relation to the symbol boundaries. The aligner keeps the two most recent words. It cuts a 10-bit window out of them at a bit offset from 0 to 9 and registers that window as the aligned symbol.

A 2-bit mode input controls how the offset moves:
- **Automatic:** the aligner hunts for comma patterns and moves the offset onto them.
- **Frozen:** the offset is held where it is.
- **Manual jog:** a host steps the offset by one bit each time it enters this mode.

Every change of offset raises a one-cycle realign pulse. The output word that straddles the change is marked invalid.

Top module: `comma_aligner`

## Requirements
- R1: While `rst` is sampled high, the next edge sets `bit_offset` to 0 and clears `out_vld` and `realign`.
- R2: `mode` encodings:
  - 2'b00: frozen.
  - 2'b01: automatic comma alignment.
  - 2'b10: jog.
  - 2'b11: reserved, which behaves as frozen. Entering 11 from 01 gives no jog step.
- R3: Bit i of `in_word` is the i-th bit received. The stream is the previous accepted word followed by the current one. The window at offset k is stream bits k to k+9, with bit 0 of `out_word` the earliest. `bit_offset` stays in the range 0 to 9.
- R4: A window holds a comma when its bits 0 to 6 are 0,0,1,1,1,1,1 or 1,1,0,0,0,0,0 (bit 0 first). When several offsets hold a comma, the lowest offset is chosen.
- R5: In mode 01, the cycle after a word is accepted and two words are held, a comma at an offset other than the current one moves `bit_offset` to that offset at the next edge. No move happens in a cycle without a freshly accepted word.
- R6: When `mode` is 2'b10 and the previous cycle's mode had its upper bit at 0, `bit_offset` advances by one, wrapping from 9 to 0. Holding 2'b10, or arriving from 2'b11, gives no step.
- R7: In modes 00 and 11, `bit_offset` never changes. This includes the first cycle after switching from another mode.
- R8: `realign` is high for exactly the cycles in which `bit_offset` differs from its previous value.
- R9: `out_word` and `out_vld` are registered one cycle after the accepted word reaches the history:
  - `out_word` is the window at the offset in force before that edge.
  - `out_vld` is high only if two words have been received since reset and the offset does not change at that same edge.
- R10: A jog mode held through reset causes no step after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Raw word present this cycle |
| in_word | input | 10 | Raw deserialized word, bit 0 received first |
| mode | input | 2 | Alignment mode (R2) |
| out_word | output | 10 | Aligned symbol |
| out_vld | output | 1 | Aligned symbol is valid |
| bit_offset | output | 4 | Current window offset |
| realign | output | 1 | Offset changed this cycle |

## Verification
The hardest situations to reach from the ports are these:
- A window where two commas compete.
- A comma that arrives at a new offset in the same cycle the mode leaves automatic alignment.
- A jog mode held across reset.

The stimulus builds a serial bit stream and packs it into words. A chosen number of filler bits before the commas sets the expected lock offset. One hand-built segment places two back-to-back commas so that offsets 1 and 8 both match. Mode changes are driven at chosen cycles while words flow, and a jog code is held through a reset pulse. A behavioural model predicts offset, word, valid and pulse every cycle.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;

  localparam int SYM_W_DEF   = 10;
  localparam int COMMA_W_DEF = 7;
  // comma seen LSB-first as 0,0,1,1,1,1,1
  localparam logic [COMMA_W_DEF-1:0] COMMA_PAT_DEF = 7'b1111100;

  typedef enum logic [1:0] {
    MODE_FROZEN = 2'b00,
    MODE_COMMA  = 2'b01,
    MODE_JOG    = 2'b10,
    MODE_RSVD   = 2'b11
  } align_mode_e;

endpackage

// File: rtl/word_history.sv
module word_history #(
  parameter int SYM_W = comma_align_pkg::SYM_W_DEF,
  localparam int SPAN_W = 2 * SYM_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [SYM_W-1:0]  in_word,
  output logic [SPAN_W-1:0] span,
  output logic              fresh,
  output logic              full
);

  logic [SYM_W-1:0] prev_q, cur_q;
  logic [1:0]       fill_q;
  logic             fresh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      cur_q   <= '0;
      fill_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= in_vld;
      if (in_vld) begin
        prev_q <= cur_q;
        cur_q  <= in_word;
        if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
      end
    end
  end

  // earliest bit at index 0; top bit of current word can never start a window
  assign span  = {cur_q[SYM_W-2:0], prev_q};
  assign fresh = fresh_q;
  assign full  = (fill_q == 2'd2);

endmodule

// File: rtl/comma_finder.sv
module comma_finder #(
  parameter int SYM_W   = comma_align_pkg::SYM_W_DEF,
  parameter int COMMA_W = comma_align_pkg::COMMA_W_DEF,
  parameter logic [COMMA_W-1:0] COMMA_PAT = comma_align_pkg::COMMA_PAT_DEF,
  localparam int OFF_W  = $clog2(SYM_W),
  localparam int SCAN_W = SYM_W + COMMA_W - 1
) (
  input  logic [SCAN_W-1:0] scan,
  output logic              hit,
  output logic [OFF_W-1:0]  hit_off
);

  logic [SYM_W-1:0] match;

  for (genvar k = 0; k < SYM_W; k++) begin : g_cand
    logic [COMMA_W-1:0] head;
    assign head     = scan[k +: COMMA_W];
    assign match[k] = (head == COMMA_PAT) || (head == ~COMMA_PAT);
  end

  // lowest matching offset wins
  always_comb begin
    hit     = 1'b0;
    hit_off = '0;
    for (int k = SYM_W - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit     = 1'b1;
        hit_off = OFF_W'(k);
      end
    end
  end

endmodule

// File: rtl/offset_ctrl.sv
module offset_ctrl #(
  parameter int SYM_W = comma_align_pkg::SYM_W_DEF,
  localparam int OFF_W = $clog2(SYM_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             eval,
  input  logic             hit,
  input  logic [OFF_W-1:0] hit_off,
  output logic [OFF_W-1:0] off_q,
  output logic [OFF_W-1:0] off_nxt,
  output logic             moved
);
  import comma_align_pkg::*;

  align_mode_e      mode_e;
  logic [1:0]       mode_q;
  logic             jog_edge;
  logic [OFF_W-1:0] off_step;

  assign mode_e   = align_mode_e'(mode);
  assign jog_edge = (mode_e == MODE_JOG) && !mode_q[1];
  assign off_step = (off_q == OFF_W'(SYM_W - 1)) ? '0 : off_q + 1'b1;

  always_comb begin
    off_nxt = off_q;
    unique case (mode_e)
      MODE_COMMA:  if (eval && hit) off_nxt = hit_off;
      MODE_JOG:    if (jog_edge)    off_nxt = off_step;
      default:     off_nxt = off_q;
    endcase
  end

  assign moved = (off_nxt != off_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      mode_q <= mode;   // track input so a held jog code is no edge
    end else begin
      off_q  <= off_nxt;
      mode_q <= mode;
    end
  end

endmodule

// File: rtl/comma_aligner.sv
module comma_aligner #(
  parameter int SYM_W   = comma_align_pkg::SYM_W_DEF,
  parameter int COMMA_W = comma_align_pkg::COMMA_W_DEF,
  localparam int OFF_W  = $clog2(SYM_W),
  localparam int SPAN_W = 2 * SYM_W - 1,
  localparam int SCAN_W = SYM_W + COMMA_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [SYM_W-1:0] in_word,
  input  logic [1:0]       mode,
  output logic [SYM_W-1:0] out_word,
  output logic             out_vld,
  output logic [OFF_W-1:0] bit_offset,
  output logic             realign
);

  logic [SPAN_W-1:0] span;
  logic              fresh, full;
  logic              hit, moved;
  logic [OFF_W-1:0]  hit_off, off_q, off_nxt;
  logic [SYM_W-1:0]  window;
  logic [SYM_W-1:0]  word_q;
  logic              vld_q, realign_q;

  word_history #(.SYM_W(SYM_W)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_word (in_word),
    .span    (span),
    .fresh   (fresh),
    .full    (full)
  );

  comma_finder #(.SYM_W(SYM_W), .COMMA_W(COMMA_W)) u_find (
    .scan    (span[SCAN_W-1:0]),
    .hit     (hit),
    .hit_off (hit_off)
  );

  offset_ctrl #(.SYM_W(SYM_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .eval    (fresh && full),
    .hit     (hit),
    .hit_off (hit_off),
    .off_q   (off_q),
    .off_nxt (off_nxt),
    .moved   (moved)
  );

  // barrel select of the window at the offset in force
  always_comb begin
    window = '0;
    for (int k = 0; k < SYM_W; k++) begin
      if (off_q == OFF_W'(k)) window = span[k +: SYM_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      vld_q     <= 1'b0;
      realign_q <= 1'b0;
    end else begin
      if (fresh) word_q <= window;
      vld_q     <= fresh && full && !moved;
      realign_q <= moved;
    end
  end

  assign out_word   = word_q;
  assign out_vld    = vld_q;
  assign bit_offset = off_q;
  assign realign    = realign_q;

endmodule

// File: rtl/comma_aligner_chk.sv
module comma_aligner_chk #(
  parameter int SYM_W = 10,
  localparam int OFF_W = $clog2(SYM_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic [1:0]       mode,
  input logic             out_vld,
  input logic [OFF_W-1:0] bit_offset,
  input logic             realign
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (bit_offset == '0 && !out_vld && !realign)); // R1

  AST_OFFSET_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_offset <= OFF_W'(SYM_W - 1)); // R3

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 || mode == 2'b11) |=> $stable(bit_offset)); // R7

  AST_JOG_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && !$past(mode[1])) |=>
      (bit_offset == (($past(bit_offset) == OFF_W'(SYM_W - 1)) ? '0 : $past(bit_offset) + 1'b1))); // R6

  AST_JOG_HELD_STILL: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && $past(mode[1])) |=> $stable(bit_offset)); // R6

  AST_COMMA_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && !$past(in_vld)) |=> $stable(bit_offset)); // R5

  AST_PULSE_ON_MOVE: assert property (@(posedge clk) disable iff (rst)
    realign == (bit_offset != $past(bit_offset))); // R8

  AST_NO_VALID_ON_MOVE: assert property (@(posedge clk) disable iff (rst)
    realign |-> !out_vld); // R9

endmodule

bind comma_aligner comma_aligner_chk #(.SYM_W(SYM_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_vld     (in_vld),
  .mode       (mode),
  .out_vld    (out_vld),
  .bit_offset (bit_offset),
  .realign    (realign)
);

// File: tb/comma_aligner_tb_top.sv
module comma_aligner_tb_top;
  localparam int W = 10;
  localparam logic [W-1:0] COMMA_N = 10'b0101111100; // 0,0,1,1,1,1,1,0,1,0
  localparam logic [W-1:0] COMMA_P = 10'b1010000011; // 1,1,0,0,0,0,0,1,0,1

  logic         clk = 1'b0, rst = 1'b1, in_vld = 1'b0;
  logic [W-1:0] in_word = '0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] out_word;
  logic         out_vld, realign;
  logic [3:0]   bit_offset;

  int vectors = 0, misses = 0, seen_comma = 0;
  bit bq[$];

  // reference model state
  logic [W-1:0]   m_prev = '0, m_cur = '0, e_word = '0;
  logic [2*W-1:0] m_cat;
  logic [1:0]     m_mode = 2'b00;
  int  m_off = 0, m_fill = 0, m_nxt = 0;
  bit  m_new = 0, e_vld = 0, e_rl = 0, live = 0, m_found = 0;

  comma_aligner dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word), .mode(mode),
    .out_word(out_word), .out_vld(out_vld), .bit_offset(bit_offset), .realign(realign)
  );

  always #5 clk = ~clk;

  function automatic logic [W-1:0] win_at(input logic [2*W-1:0] c, input int k);
    logic [2*W-1:0] s;
    s = c >> k;
    return s[W-1:0];
  endfunction

  function automatic bit is_comma(input logic [W-1:0] w);
    return (w[6:0] == 7'b1111100) || (w[6:0] == 7'b0000011);
  endfunction

  always @(posedge clk) begin
    live = 1;
    if (rst) begin
      m_off = 0; m_mode = mode; m_fill = 0; m_new = 0;
      e_vld = 0; e_rl = 0; e_word = '0; m_prev = '0; m_cur = '0;
    end else begin
      m_nxt = m_off; m_cat = {m_cur, m_prev}; m_found = 0;
      if (mode == 2'b01 && m_new && m_fill >= 2)
        for (int k = 0; k < W; k++)
          if (!m_found && is_comma(win_at(m_cat, k))) begin
            m_found = 1; m_nxt = k;
          end
      if (mode == 2'b10 && !m_mode[1]) m_nxt = (m_off + 1) % W;
      if (m_new) e_word = win_at(m_cat, m_off);
      e_vld = m_new && (m_fill >= 2) && (m_nxt == m_off);
      e_rl  = (m_nxt != m_off);
      m_off = m_nxt; m_mode = mode;
      if (in_vld) begin
        m_prev = m_cur; m_cur = in_word;
        if (m_fill < 2) m_fill++;
      end
      m_new = in_vld;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk(bit_offset == m_off, "R5/R6/R7 offset", bit_offset, m_off);
      chk(realign == e_rl, "R8 realign", realign, e_rl);
      chk(out_vld == e_vld, "R9 out_vld", out_vld, e_vld);
      if (e_vld) chk(out_word == e_word, "R3 out_word", out_word, e_word);
      if (out_vld && out_word == COMMA_N) seen_comma++;
    end
  end

  task automatic push_sym(input logic [W-1:0] s);
    for (int i = 0; i < W; i++) bq.push_back(s[i]);
  endtask

  task automatic push_fill(input int n);
    for (int i = 0; i < n; i++) bq.push_back(i % 2 == 0);
  endtask

  task automatic idle(input int n);
    in_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input bit gaps);
    int j;
    logic [W-1:0] w;
    j = 0;
    while (bq.size() > 0) begin
      for (int i = 0; i < W; i++) w[i] = (bq.size() > 0) ? bq.pop_front() : (i % 2 == 0);
      @(negedge clk);
      in_vld = 1'b1; in_word = w;
      if (gaps && (j % 3 == 2)) begin @(negedge clk); in_vld = 1'b0; end
      j++;
    end
    idle(3);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    misses++; vectors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int start;
    repeat (3) @(negedge clk);
    chk(bit_offset == 0 && !out_vld && !realign, "R1 reset state", bit_offset, 0);
    rst = 1'b0;
    idle(2);

    // R5: automatic lock, negative-disparity comma, shift 3
    mode = 2'b01;
    push_fill(3);
    repeat (4) begin push_sym(COMMA_N); repeat (3) push_sym(10'b0101010101); end
    drain(1'b1);
    chk(bit_offset == 3, "R5 lock offset", bit_offset, 3);
    chk(seen_comma > 0, "R3 aligned comma seen", seen_comma, 1);

    // R4: positive-disparity comma, shift 7
    bq.delete();
    push_fill(7);
    repeat (3) begin push_sym(COMMA_P); push_sym(10'b0101010101); end
    drain(1'b0);
    chk(bit_offset == 7, "R4 complement comma lock", bit_offset, 7);

    // R4: two commas in one span, offsets 1 and 8, lowest wins
    push_sym(10'b0101010101);
    bq.push_back(1'b1);
    repeat (2) begin
      bq.push_back(1'b0); bq.push_back(1'b0);
      repeat (5) bq.push_back(1'b1);
    end
    push_fill(5);
    push_sym(10'b0101010101);
    drain(1'b0);
    chk(bit_offset == 1, "R4 lowest offset wins", bit_offset, 1);

    // R7: frozen, switch made while a comma at another offset arrives
    push_fill(5);
    push_sym(COMMA_N); push_sym(10'b0101010101);
    for (int i = 0; i < W; i++) in_word[i] = bq.pop_front();
    @(negedge clk); in_vld = 1'b1;
    for (int i = 0; i < W; i++) in_word[i] = bq.pop_front();
    @(negedge clk); mode = 2'b00;
    for (int i = 0; i < W; i++) in_word[i] = bq.pop_front();
    drain(1'b0);
    chk(bit_offset == 1, "R7 frozen on switch", bit_offset, 1);
    push_fill(4); repeat (3) push_sym(COMMA_N);
    drain(1'b1);
    chk(bit_offset == 1, "R7 frozen with commas", bit_offset, 1);

    // R6: jog steps once per entry
    mode = 2'b10; idle(5);
    chk(bit_offset == 2, "R6 jog single step", bit_offset, 2);
    mode = 2'b00; idle(1); mode = 2'b10; idle(3);
    chk(bit_offset == 3, "R6 jog re-entry", bit_offset, 3);
    start = 0;
    while (bit_offset != 9 && start < 12) begin
      mode = 2'b00; idle(1); mode = 2'b10; idle(2); start++;
    end
    chk(bit_offset == 9, "R6 jog reach 9", bit_offset, 9);
    mode = 2'b00; idle(1); mode = 2'b10; idle(2);
    chk(bit_offset == 0, "R6 jog wrap", bit_offset, 0);

    // R2: reserved code holds, 01 -> 11 no step, 11 -> 10 no step
    mode = 2'b01; idle(2); mode = 2'b11;
    push_fill(6); repeat (3) push_sym(COMMA_N);
    drain(1'b0);
    chk(bit_offset == 0, "R2 reserved holds", bit_offset, 0);
    mode = 2'b10; idle(3);
    chk(bit_offset == 0, "R2 from 11 no jog", bit_offset, 0);

    // R10: jog held through reset
    rst = 1'b1; idle(3); rst = 1'b0; idle(4);
    chk(bit_offset == 0, "R10 no jog after reset", bit_offset, 0);
    mode = 2'b00; idle(2);
    summary();
  end

endmodule